// File: doc/BRIEF.md
# Contactless Card Block-Protocol Responder

This block is the card-side data-link controller of a half-duplex block transmission protocol. A receiver in front of it decodes each incoming frame into a protocol control byte (PCB) and an optional logical card identifier (CID). It also passes a strobe that says whether the frame arrived without transmission errors. The responder then decides whether the block is addressed to this card and tracks the one-bit block number. It picks the reply: an information block (I-block) carrying application data, a positive acknowledge (R(ACK)), a retransmission of the last block, a waiting-time extension request (S(WTX)), or a deselect response (S(DESELECT)).

The application side is reduced to a single `app_ready_i` level that says whether reply data is available. A transmitter behind the block builds the outgoing frame from the reply PCB, the CID and, for S(WTX), the one-byte INF field. Framing, CRC and the activation handshake sit outside. Activation is signalled by a one-cycle pulse on `act_i`.

Top module: `card_blk_responder`

## Requirements
- R1: After reset the card is halted: no reply is produced, `halted_o`=1 and `blk_num_o`=1. A pulse on `act_i` clears `halted_o` and sets the block number to 1, with no reply.
- R2: PCB bit 1 must be 1. Bits 7:6 give the type: 00 is an I-block, 10 an R-block, 11 an S-block and 01 is invalid. An R-block needs bit 5=1; there, bit 4=1 marks R(NAK) and 0 marks R(ACK). In an S-block, bits 5:4=00 is DESELECT and 11 is WTX. R- and S-blocks with bit 2 (NAD follows) set are invalid. Bit 0 is the block number, bit 3 means a CID follows and bit 4 of an I-block is the chaining flag. Invalid blocks get no reply.
- R3: An accepted I-block always toggles the block number. An accepted R(ACK) toggles it only when its number differs from the current one. Nothing else changes it.
- R4: A chained I-block is answered with R(ACK) PCB 0xA2|CID<<3|bn. An unchained I-block with `app_ready_i`=1 is answered with I-block PCB 0x02|CID<<3|NAD<<2|bn. Here bn is the toggled block number, and reply kind codes are I=1, R(ACK)=2, retransmit=3, WTX=4, DESELECT=5.
- R5: An R(ACK) or R(NAK) whose number equals the current one makes the card resend its last reply PCB unchanged (kind 3), without toggling.
- R6: An R(NAK) with a different number is answered with R(ACK) carrying the current, untoggled number.
- R7: With `cid_en_i`=1 the card accepts blocks whose CID equals `my_cid_i`, and blocks with no CID only when `my_cid_i`=0. With `cid_en_i`=0 it accepts only blocks without CID. A reply has a CID (value `my_cid_i`) exactly when the received block had one.
- R8: A block with `rx_ok_i`=0 is dropped silently, with no reply and no state change. The card never emits an R-block with bit 4 set.
- R9: When an I-block reply is due but `app_ready_i`=0, the card sends S(WTX) PCB 0xF2|CID<<3 with INF {00, WTXM}. A later S(WTX) response brings the delayed I-block if ready, otherwise another S(WTX). An S(WTX) with no extension pending is ignored.
- R10: S(DESELECT) is answered with PCB 0xC2|CID<<3, after which the card is halted and ignores every block until the next activation.
- R11: A reply I-block carries the NAD flag when the first block of the received chain carried one. R(ACK)-triggered I-blocks carry none.
- R12: Every reply, block-number change and halt-state change appears one clock edge after the strobe that caused it, as a one-cycle `tx_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_i | input | 1 | One-cycle activation pulse |
| cid_en_i | input | 1 | Card supports CID addressing |
| my_cid_i | input | 4 | Logical identifier assigned to the card |
| rx_valid_i | input | 1 | Received-block strobe |
| rx_ok_i | input | 1 | Block received without transmission error |
| rx_pcb_i | input | 8 | Received PCB |
| rx_cid_i | input | 4 | Received CID value (when PCB bit 3 set) |
| app_ready_i | input | 1 | Application reply data available |
| tx_valid_o | output | 1 | Reply strobe |
| tx_kind_o | output | 3 | Reply kind code |
| tx_pcb_o | output | 8 | Reply PCB |
| tx_cid_o | output | 4 | Reply CID value |
| tx_inf_o | output | 8 | Reply INF byte for S(WTX) |
| blk_num_o | output | 1 | Current block number |
| halted_o | output | 1 | Card is halted |

## Verification
Each result is due exactly one rising edge after the strobe that causes it. This holds for the reply PCB and kind, the block number and the halt flag, because every one of them is registered once and nothing else is. The bench raises a strobe at a falling edge and drops it at the next falling edge, then samples all outputs at that same point. That point lies half a period after the edge that loaded them and before the next edge could clear the reply pulse. Ignored blocks are checked at that same point, through a low `tx_valid_o` and an unchanged `blk_num_o`.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;
  localparam int PCB_W    = 8;
  localparam int PCB_BN   = 0;
  localparam int PCB_FIX  = 1;
  localparam int PCB_NAD  = 2;
  localparam int PCB_CID  = 3;
  localparam int PCB_MORE = 4;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_I     = 3'd1,
    K_RACK  = 3'd2,
    K_RETX  = 3'd3,
    K_WTX   = 3'd4,
    K_DESEL = 3'd5
  } reply_e;

  typedef enum logic [2:0] {
    C_BAD, C_I, C_RACK, C_RNAK, C_SWTX, C_SDES
  } cls_e;

  // Block class from a PCB; anything malformed maps to C_BAD.
  function automatic cls_e classify(input logic [PCB_W-1:0] p);
    cls_e c;
    c = C_BAD;
    if (p[PCB_FIX]) begin
      case (p[7:6])
        2'b00: c = C_I;
        2'b10: if (p[5] && !p[PCB_NAD]) c = p[PCB_MORE] ? C_RNAK : C_RACK;
        2'b11: if (!p[PCB_NAD]) begin
                 if (p[5:4] == 2'b00)      c = C_SDES;
                 else if (p[5:4] == 2'b11) c = C_SWTX;
               end
        default: c = C_BAD;
      endcase
    end
    return c;
  endfunction

  // Reply PCB for a given kind and prologue flags.
  function automatic logic [PCB_W-1:0] mk_pcb(input reply_e k, input logic cidf,
                                               input logic nadf, input logic bn);
    logic [PCB_W-1:0] p;
    case (k)
      K_I:     p = {2'b00, 2'b00, cidf, nadf, 1'b1, bn};
      K_RACK:  p = {2'b10, 2'b10, cidf, 1'b0, 1'b1, bn};
      K_WTX:   p = {2'b11, 2'b11, cidf, 1'b0, 1'b1, 1'b0};
      K_DESEL: p = {2'b11, 2'b00, cidf, 1'b0, 1'b1, 1'b0};
      default: p = '0;
    endcase
    return p;
  endfunction

  function automatic logic [7:0] wtx_inf(input logic [5:0] mult);
    return {2'b00, mult};
  endfunction
endpackage

// File: rtl/cbr_decode.sv
`timescale 1ns/1ps
module cbr_decode
  import cbr_pkg::*;
#(
  parameter int CID_W = 4
) (
  input  logic             rx_valid_i,
  input  logic             rx_ok_i,
  input  logic [PCB_W-1:0] rx_pcb_i,
  input  logic [CID_W-1:0] rx_cid_i,
  input  logic             cid_en_i,
  input  logic [CID_W-1:0] my_cid_i,
  output logic             hit_o,
  output cls_e             cls_o,
  output logic             bn_o,
  output logic             cidf_o,
  output logic             nadf_o,
  output logic             more_o
);
  logic id_ok;

  assign bn_o   = rx_pcb_i[PCB_BN];
  assign cidf_o = rx_pcb_i[PCB_CID];
  assign nadf_o = rx_pcb_i[PCB_NAD];
  assign more_o = rx_pcb_i[PCB_MORE];

  // identifier filter, including the "identifier zero answers CID-less" case
  always_comb begin
    if (!cid_en_i)   id_ok = !cidf_o;
    else if (cidf_o) id_ok = (rx_cid_i == my_cid_i);
    else             id_ok = (my_cid_i == '0);
  end

  assign cls_o = classify(rx_pcb_i);
  assign hit_o = rx_valid_i && rx_ok_i && id_ok;
endmodule

// File: rtl/cbr_number.sv
`timescale 1ns/1ps
module cbr_number
  import cbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic hit_i,
  input  cls_e cls_i,
  input  logic bn_i,
  input  logic desel_i,
  output logic blk_o,
  output logic halted_o,
  output logic tog_o
);
  logic blk_q, halted_q;

  assign tog_o = hit_i && !halted_q && !act_i &&
                 ((cls_i == C_I) || ((cls_i == C_RACK) && (bn_i != blk_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q    <= 1'b1;
      halted_q <= 1'b1;
    end else if (act_i) begin
      blk_q    <= 1'b1;
      halted_q <= 1'b0;
    end else begin
      if (tog_o)   blk_q    <= ~blk_q;
      if (desel_i) halted_q <= 1'b1;
    end
  end

  assign blk_o    = blk_q;
  assign halted_o = halted_q;

  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tog_o |=> (blk_q != $past(blk_q)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog_o && !act_i) |=> $stable(blk_q));
  p_activate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (blk_q && !halted_q));
endmodule

// File: rtl/cbr_reply.sv
`timescale 1ns/1ps
module cbr_reply
  import cbr_pkg::*;
#(
  parameter int         CID_W = 4,
  parameter logic [5:0] WTXM  = 6'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid_i,
  input  logic             act_i,
  input  logic             hit_i,
  input  cls_e             cls_i,
  input  logic             bn_i,
  input  logic             cidf_i,
  input  logic             nadf_i,
  input  logic             more_i,
  input  logic             app_ready_i,
  input  logic             blk_i,
  input  logic             tog_i,
  input  logic             halted_i,
  input  logic [CID_W-1:0] my_cid_i,
  output logic             desel_o,
  output logic             tx_valid_o,
  output reply_e           tx_kind_o,
  output logic [PCB_W-1:0] tx_pcb_o,
  output logic [CID_W-1:0] tx_cid_o,
  output logic [7:0]       tx_inf_o
);
  logic             live, blk_nx, nad_eff;
  reply_e           kind_d;
  logic [PCB_W-1:0] pcb_d;
  logic             set_wtx, clr_wtx, nad_nx, chain_nx;

  logic [PCB_W-1:0] last_pcb_q;
  logic             wtx_pend_q, chain_q, nad_hold_q;
  logic             tx_valid_q;
  reply_e           tx_kind_q;
  logic [PCB_W-1:0] tx_pcb_q;
  logic [CID_W-1:0] tx_cid_q;
  logic [7:0]       tx_inf_q;

  assign live    = hit_i && !halted_i && !act_i;
  assign blk_nx  = blk_i ^ tog_i;
  assign nad_eff = chain_q ? nad_hold_q : nadf_i;
  assign desel_o = live && (cls_i == C_SDES);

  always_comb begin
    kind_d   = K_NONE;
    pcb_d    = last_pcb_q;
    set_wtx  = 1'b0;
    clr_wtx  = 1'b0;
    nad_nx   = nad_hold_q;
    chain_nx = chain_q;
    if (live) begin
      case (cls_i)
        C_I: begin
          nad_nx   = nad_eff;
          chain_nx = more_i;
          if (more_i) begin
            kind_d = K_RACK; pcb_d = mk_pcb(K_RACK, cidf_i, 1'b0, blk_nx);
          end else if (app_ready_i) begin
            kind_d = K_I; pcb_d = mk_pcb(K_I, cidf_i, nad_eff, blk_nx);
          end else begin
            kind_d = K_WTX; pcb_d = mk_pcb(K_WTX, cidf_i, 1'b0, 1'b0); set_wtx = 1'b1;
          end
        end
        C_RACK: begin
          if (bn_i == blk_i) begin
            kind_d = K_RETX;
          end else begin
            nad_nx = 1'b0;
            if (app_ready_i) begin
              kind_d = K_I; pcb_d = mk_pcb(K_I, cidf_i, 1'b0, blk_nx);
            end else begin
              kind_d = K_WTX; pcb_d = mk_pcb(K_WTX, cidf_i, 1'b0, 1'b0); set_wtx = 1'b1;
            end
          end
        end
        C_RNAK: begin
          if (bn_i == blk_i) kind_d = K_RETX;
          else begin
            kind_d = K_RACK; pcb_d = mk_pcb(K_RACK, cidf_i, 1'b0, blk_i);
          end
        end
        C_SWTX: begin
          if (wtx_pend_q) begin
            if (app_ready_i) begin
              kind_d = K_I; pcb_d = mk_pcb(K_I, cidf_i, nad_hold_q, blk_i); clr_wtx = 1'b1;
            end else begin
              kind_d = K_WTX; pcb_d = mk_pcb(K_WTX, cidf_i, 1'b0, 1'b0);
            end
          end
        end
        C_SDES: begin
          kind_d = K_DESEL; pcb_d = mk_pcb(K_DESEL, cidf_i, 1'b0, 1'b0); clr_wtx = 1'b1;
        end
        default: kind_d = K_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pcb_q <= '0;
      wtx_pend_q <= 1'b0;
      chain_q    <= 1'b0;
      nad_hold_q <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_kind_q  <= K_NONE;
      tx_pcb_q   <= '0;
      tx_cid_q   <= '0;
      tx_inf_q   <= '0;
    end else begin
      if (act_i) begin
        wtx_pend_q <= 1'b0;
        chain_q    <= 1'b0;
        nad_hold_q <= 1'b0;
      end else begin
        if (set_wtx)      wtx_pend_q <= 1'b1;
        else if (clr_wtx) wtx_pend_q <= 1'b0;
        chain_q    <= chain_nx;
        nad_hold_q <= nad_nx;
      end
      tx_valid_q <= (kind_d != K_NONE);
      tx_kind_q  <= kind_d;
      if (kind_d != K_NONE) begin
        last_pcb_q <= pcb_d;
        tx_pcb_q   <= pcb_d;
        tx_cid_q   <= pcb_d[PCB_CID] ? my_cid_i : '0;
        tx_inf_q   <= (pcb_d[7:4] == 4'hF) ? wtx_inf(WTXM) : 8'h00;
      end
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_kind_o  = tx_kind_q;
  assign tx_pcb_o   = tx_pcb_q;
  assign tx_cid_o   = tx_cid_q;
  assign tx_inf_o   = tx_inf_q;

  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_q |-> $past(rx_valid_i));
  p_no_nak_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_q |-> !((tx_pcb_q[7:6] == 2'b10) && tx_pcb_q[PCB_MORE]));
  p_halt_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_i && !act_i) |=> !tx_valid_q);
  p_retx_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_q && (tx_kind_q == K_RETX)) |-> (tx_pcb_q == $past(last_pcb_q)));
  p_wtx_inf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_q && (tx_kind_q == K_WTX)) |-> (tx_inf_q == {2'b00, WTXM}));
endmodule

// File: rtl/card_blk_responder.sv
`timescale 1ns/1ps
module card_blk_responder
  import cbr_pkg::*;
#(
  parameter int         CID_W = 4,
  parameter logic [5:0] WTXM  = 6'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             cid_en_i,
  input  logic [CID_W-1:0] my_cid_i,
  input  logic             rx_valid_i,
  input  logic             rx_ok_i,
  input  logic [7:0]       rx_pcb_i,
  input  logic [CID_W-1:0] rx_cid_i,
  input  logic             app_ready_i,
  output logic             tx_valid_o,
  output logic [2:0]       tx_kind_o,
  output logic [7:0]       tx_pcb_o,
  output logic [CID_W-1:0] tx_cid_o,
  output logic [7:0]       tx_inf_o,
  output logic             blk_num_o,
  output logic             halted_o
);
  logic   hit, bn, cidf, nadf, more, blk, tog, halted, desel;
  cls_e   cls;
  reply_e kind;

  cbr_decode #(.CID_W(CID_W)) u_dec (
    .rx_valid_i(rx_valid_i), .rx_ok_i(rx_ok_i), .rx_pcb_i(rx_pcb_i),
    .rx_cid_i(rx_cid_i), .cid_en_i(cid_en_i), .my_cid_i(my_cid_i),
    .hit_o(hit), .cls_o(cls), .bn_o(bn), .cidf_o(cidf), .nadf_o(nadf), .more_o(more)
  );

  cbr_number u_num (
    .clk(clk), .rst_n(rst_n), .act_i(act_i), .hit_i(hit), .cls_i(cls), .bn_i(bn),
    .desel_i(desel), .blk_o(blk), .halted_o(halted), .tog_o(tog)
  );

  cbr_reply #(.CID_W(CID_W), .WTXM(WTXM)) u_rep (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid_i), .act_i(act_i), .hit_i(hit),
    .cls_i(cls), .bn_i(bn), .cidf_i(cidf), .nadf_i(nadf), .more_i(more),
    .app_ready_i(app_ready_i), .blk_i(blk), .tog_i(tog), .halted_i(halted),
    .my_cid_i(my_cid_i), .desel_o(desel), .tx_valid_o(tx_valid_o), .tx_kind_o(kind),
    .tx_pcb_o(tx_pcb_o), .tx_cid_o(tx_cid_o), .tx_inf_o(tx_inf_o)
  );

  assign tx_kind_o = kind;
  assign blk_num_o = blk;
  assign halted_o  = halted;

  p_desel_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && (tx_kind_o == 3'd5)) |-> halted_o);
endmodule

// File: tb/test_card_blk_responder.sv
`timescale 1ns/1ps
module test_card_blk_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act = 1'b0, cid_en = 1'b1, rx_valid = 1'b0, rx_ok = 1'b1, app_ready = 1'b1;
  logic [3:0] my_cid = 4'd0, rx_cid = 4'd0;
  logic [7:0] rx_pcb = 8'h00;
  logic       tx_valid, blk_num, halted;
  logic [2:0] tx_kind;
  logic [7:0] tx_pcb, tx_inf;
  logic [3:0] tx_cid;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  card_blk_responder i_card_blk_responder (
    .clk(clk), .rst_n(rst_n), .act_i(act), .cid_en_i(cid_en), .my_cid_i(my_cid),
    .rx_valid_i(rx_valid), .rx_ok_i(rx_ok), .rx_pcb_i(rx_pcb), .rx_cid_i(rx_cid),
    .app_ready_i(app_ready), .tx_valid_o(tx_valid), .tx_kind_o(tx_kind),
    .tx_pcb_o(tx_pcb), .tx_cid_o(tx_cid), .tx_inf_o(tx_inf),
    .blk_num_o(blk_num), .halted_o(halted)
  );

  // {act, ok, ready, pcb, exp_valid, exp_kind, exp_pcb, exp_blk}
  localparam int NV = 21;
  typedef logic [23:0] vec_t;
  localparam vec_t TBL [NV] = '{
    {1'b1,1'b1,1'b1,8'h00, 1'b0,3'd0,8'h00,1'b1}, // R1 activation
    {1'b0,1'b1,1'b1,8'h02, 1'b1,3'd1,8'h02,1'b0}, // R4 I -> I, R3 toggle
    {1'b0,1'b1,1'b1,8'hA2, 1'b1,3'd3,8'h02,1'b0}, // R5 ACK equal -> resend
    {1'b0,1'b1,1'b1,8'hB2, 1'b1,3'd3,8'h02,1'b0}, // R5 NAK equal -> resend
    {1'b0,1'b1,1'b1,8'hB3, 1'b1,3'd2,8'hA2,1'b0}, // R6 NAK differ -> ACK
    {1'b0,1'b1,1'b1,8'h1E, 1'b1,3'd2,8'hAB,1'b1}, // R4 chained, CID+NAD
    {1'b0,1'b1,1'b1,8'h0B, 1'b1,3'd1,8'h0E,1'b0}, // R11 NAD from chain start
    {1'b0,1'b1,1'b0,8'h03, 1'b1,3'd4,8'hF2,1'b1}, // R9 not ready -> WTX
    {1'b0,1'b1,1'b0,8'hF2, 1'b1,3'd4,8'hF2,1'b1}, // R9 still not ready
    {1'b0,1'b1,1'b1,8'hF2, 1'b1,3'd1,8'h03,1'b1}, // R9 delayed I-block
    {1'b0,1'b1,1'b1,8'hF2, 1'b0,3'd0,8'h00,1'b1}, // R9 WTX without pending
    {1'b0,1'b0,1'b1,8'h02, 1'b0,3'd0,8'h00,1'b1}, // R8 transmission error
    {1'b0,1'b1,1'b1,8'h42, 1'b0,3'd0,8'h00,1'b1}, // R2 type 01 invalid
    {1'b0,1'b1,1'b1,8'hA2, 1'b1,3'd1,8'h02,1'b0}, // R3 ACK differ toggles
    {1'b0,1'b1,1'b0,8'hA3, 1'b1,3'd4,8'hF2,1'b1}, // R9 ACK differ, not ready
    {1'b0,1'b1,1'b1,8'hA3, 1'b1,3'd3,8'hF2,1'b1}, // R5 resend WTX
    {1'b0,1'b1,1'b1,8'hE2, 1'b0,3'd0,8'h00,1'b1}, // R2 bad S-block
    {1'b0,1'b1,1'b1,8'hC2, 1'b1,3'd5,8'hC2,1'b1}, // R10 deselect
    {1'b0,1'b1,1'b1,8'h02, 1'b0,3'd0,8'h00,1'b1}, // R10 halted ignores
    {1'b1,1'b1,1'b1,8'h00, 1'b0,3'd0,8'h00,1'b1}, // R1 reactivation
    {1'b0,1'b1,1'b1,8'h02, 1'b1,3'd1,8'h02,1'b0}  // R4 after reactivation
  };

  task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expct);
    checks++;
    if (actual !== expct) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expct);
    end
  endtask

  task automatic send(input logic ok, input logic rdy, input logic [7:0] pcb,
                      input logic [3:0] cid);
    @(negedge clk);
    rx_valid = 1'b1; rx_ok = ok; app_ready = rdy; rx_pcb = pcb; rx_cid = cid;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic activate();
    @(negedge clk); act = 1'b1;
    @(negedge clk); act = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset halted", 32'(halted), 32'd1);
    chk("R1 reset no reply", 32'(tx_valid), 32'd0);
    chk("R1 reset block number", 32'(blk_num), 32'd1);
    send(1'b1, 1'b1, 8'h02, 4'd0);
    chk("R10 ignored before activation", 32'(tx_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      if (v[23]) activate();
      else send(v[22], v[21], v[20:13], 4'd0);
      chk($sformatf("R12 strobe row %0d", i), 32'(tx_valid), 32'(v[12]));
      if (v[12]) begin
        chk($sformatf("R4 kind row %0d", i), 32'(tx_kind), 32'(v[11:9]));
        chk($sformatf("R2 pcb row %0d", i), 32'(tx_pcb), 32'(v[8:1]));
      end
      chk($sformatf("R3 block number row %0d", i), 32'(blk_num), 32'(v[0]));
    end

    // R9: INF byte of a waiting-time extension
    send(1'b1, 1'b0, 8'h02, 4'd0);
    chk("R9 WTX kind", 32'(tx_kind), 32'd4);
    chk("R9 WTX INF", 32'(tx_inf), 32'h04);
    // R10: halted flag after deselect
    send(1'b1, 1'b1, 8'hC2, 4'd0);
    chk("R10 halted after deselect", 32'(halted), 32'd1);
    activate();
    chk("R1 active after pulse", 32'(halted), 32'd0);

    // R7: identifier filter with identifier 5
    my_cid = 4'd5;
    send(1'b1, 1'b1, 8'h0A, 4'd5);
    chk("R7 own CID answered", 32'(tx_valid), 32'd1);
    chk("R7 reply has CID flag", 32'(tx_pcb[3]), 32'd1);
    chk("R7 reply CID value", 32'(tx_cid), 32'd5);
    send(1'b1, 1'b1, 8'h0A, 4'd3);
    chk("R7 other CID ignored", 32'(tx_valid), 32'd0);
    send(1'b1, 1'b1, 8'h02, 4'd0);
    chk("R7 no CID ignored when id nonzero", 32'(tx_valid), 32'd0);
    cid_en = 1'b0;
    send(1'b1, 1'b1, 8'h0A, 4'd5);
    chk("R7 CID block ignored without support", 32'(tx_valid), 32'd0);
    send(1'b1, 1'b1, 8'h02, 4'd0);
    chk("R7 CID-less answered without support", 32'(tx_valid), 32'd1);
    chk("R7 reply without CID flag", 32'(tx_pcb[3]), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule